// File: doc/BRIEF.md
# Power-of-Two Prescaled PWM Generator

This block drives one pulse-width-modulated output from a source clock. A prescaler divides the source clock by a power of two chosen by a 4-bit select value. Each prescaler tick advances an 8-bit period counter, so one PWM period spans 256 ticks. The output is high while the counter is below the duty value, which gives a duty cycle of n/256.

Two overrides sit in front of the modulator. A force-high input drives the output high whatever the other controls say. With force-high clear, the output is held low unless the block is enabled and not in power save. That lets the pin act as a plain general-purpose output when the modulator is not in use. Duty and divide changes take effect only at a period boundary, so the waveform never shows a partial period.

Top module: `pwm_pow2_gen`

## Requirements
- R1: The prescaler divides by 2^m, where m is the 4-bit `div_sel` value, so each counter step lasts 2^m source cycles. m = 0 applies no division.
- R2: Within a period, `pwm_out` is high while the period counter is below the 8-bit `duty` value n, for n × 2^m cycles. n = 0 gives a constant low output.
- R3: One PWM period lasts 256 × 2^m source cycles, and the high phase restarts at the start of each period.
- R4: With `force_high` = 1, `pwm_out` is 1 regardless of `enable` and `power_save`.
- R5: With `force_high` = 0, `pwm_out` is 0 whenever `enable` = 0 or `power_save` = 1.
- R6: A change to `duty` or `div_sel` while running is applied only at the start of the next 256-step period.
- R7: While the block is not running (`enable` = 0 or `power_save` = 1), the prescaler and period counter are held at zero. On re-enable a new period starts with its high phase from the beginning.
- R8: While `rst_n` is low, the counters are cleared, and `pwm_out` is 0 unless `force_high` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the modulator when 1 |
| force_high | input | 1 | Drives the output high when 1; highest priority |
| power_save | input | 1 | Stops the modulator when 1, whatever `enable` is |
| div_sel | input | 4 | Prescaler exponent m; division is 2^m |
| duty | input | 8 | Duty value n; high fraction is n/256 |
| pwm_out | output | 1 | PWM or static output |

## Verification
The hardest case to reach is a control change in the middle of a period. From the ports it has to be shown that the new value does not act until the period boundary. To do this, the bench enables the block from a known zero-counter state and counts cycles from there. It changes `duty` or `div_sel` at a fixed offset, then samples the output at cycles where a premature update and a deferred update give opposite levels. A similar method covers restart after disable. The bench drops `enable` for one cycle partway through a high phase, and checks that the next high phase lasts a full n steps rather than the remainder.

// File: rtl/pwm_pow2_gen.sv
module pwm_pow2_gen #(
  parameter int DIV_W  = 4,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              force_high,
  input  logic              power_save,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_out
);
  localparam int PRE_W = (1 << DIV_W) - 1;
  localparam logic [DUTY_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0]  pre_cnt, pre_lim;
  logic [DUTY_W-1:0] cnt, duty_lat;
  logic [DIV_W-1:0]  div_lat;
  logic              active, tick, wrap;

  assign active  = enable & ~power_save;
  assign pre_lim = ~({PRE_W{1'b1}} << div_lat);
  assign tick    = (pre_cnt == pre_lim);
  assign wrap    = tick & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (!active) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      cnt     <= cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_lat <= '0;
      div_lat  <= '0;
    end else if (!active || wrap) begin
      duty_lat <= duty;
      div_lat  <= div_sel;
    end
  end

  assign pwm_out = force_high | (active & (cnt < duty_lat));

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0 && pre_cnt == '0)); // R7
  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wrap) |=> ($stable(duty_lat) && $stable(div_lat))); // R6
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_lim); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_high && duty_lat == '0) |-> !pwm_out); // R2
  AST_SLEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_high && power_save) |-> !pwm_out); // R5
endmodule

// File: tb/sim_pwm_pow2_gen.sv
module sim_pwm_pow2_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       force_high = 1'b0;
  logic       power_save = 1'b0;
  logic [3:0] div_sel = '0;
  logic [7:0] duty = '0;
  logic       pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_pow2_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .force_high(force_high),
    .power_save(power_save), .div_sel(div_sel), .duty(duty), .pwm_out(pwm_out)
  );

  // entries: {m[3:0], n[7:0]}
  localparam logic [11:0] VEC [0:6] = '{
    12'h0_00, 12'h0_FF, 12'h0_80, 12'h1_01, 12'h2_40, 12'h3_C8, 12'h0_01
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic arm(input logic [3:0] m, input logic [7:0] n);
    enable = 1'b0; div_sel = m; duty = n;
    step();
    enable = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1 chk("R8 reset low", int'(pwm_out), 0);
    force_high = 1'b1;
    #1 chk("R8 reset force high", int'(pwm_out), 1);
    force_high = 1'b0;
    step();
    rst_n = 1'b1;
    step();

    foreach (VEC[k]) begin
      automatic int m = int'(VEC[k][11:8]);
      automatic int n = int'(VEC[k][7:0]);
      automatic int per = 256 << m;
      automatic int highs = 0;
      automatic int edge_lvl = 0;
      arm(VEC[k][11:8], VEC[k][7:0]);
      for (int i = 0; i <= per; i++) begin
        #1;
        if (i < per) highs += int'(pwm_out);
        else edge_lvl = int'(pwm_out);
        step();
      end
      chk("R1 high time scales by 2^m", highs, n << m);
      chk("R2 high count n steps", highs >> m, n);
      chk("R3 next period starts high", edge_lvl, (n > 0) ? 1 : 0);
      enable = 1'b0;
      step();
    end

    arm(4'd0, 8'd255);
    step();
    force_high = 1'b1; enable = 1'b0;
    #1 chk("R4 force with enable low", int'(pwm_out), 1);
    power_save = 1'b1; enable = 1'b1;
    #1 chk("R4 force in power save", int'(pwm_out), 1);
    force_high = 1'b0;
    #1 chk("R5 power save low", int'(pwm_out), 0);
    step();
    #1 chk("R5 power save stays low", int'(pwm_out), 0);
    power_save = 1'b0; enable = 1'b0;
    #1 chk("R5 disabled low", int'(pwm_out), 0);

    begin
      automatic int late_highs = 0;
      automatic int edge_lvl = 0;
      arm(4'd0, 8'd0);
      for (int i = 0; i <= 256; i++) begin
        #1;
        if (i > 10 && i < 256) late_highs += int'(pwm_out);
        if (i == 256) edge_lvl = int'(pwm_out);
        if (i == 10) duty = 8'd255;
        step();
      end
      chk("R6 duty deferred in period", late_highs, 0);
      chk("R6 duty applied at boundary", edge_lvl, 1);
      enable = 1'b0;
      step();
    end

    begin
      automatic int mid = 0;
      automatic int edge_lvl = 0;
      arm(4'd0, 8'd128);
      for (int i = 0; i <= 256; i++) begin
        #1;
        if (i == 128) mid = int'(pwm_out);
        if (i == 256) edge_lvl = int'(pwm_out);
        if (i == 10) div_sel = 4'd1;
        step();
      end
      chk("R6 divide deferred mid", mid, 0);
      chk("R6 divide deferred edge", edge_lvl, 1);
      enable = 1'b0;
      step();
    end

    begin
      automatic int run = 0;
      automatic bit stop = 1'b0;
      arm(4'd0, 8'd128);
      for (int i = 0; i < 50; i++) step();
      enable = 1'b0;
      step();
      enable = 1'b1;
      for (int i = 0; i < 256; i++) begin
        #1;
        if (!stop && pwm_out) run++;
        else stop = 1'b1;
        step();
      end
      chk("r7 restart full high phase", run, 128);
      enable = 1'b0;
      step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule